// File: doc/BRIEF.md
# DDC Byte FIFO with Threshold Requests

This block is the byte buffer inside a display data channel controller. It sits between a register-mapped host port and the I2C byte engine. A direction input decides who fills it and who empties it. In transmit use, the host writes bytes and the engine drains them. In receive use, the engine deposits bytes and the host reads them out. The oldest byte is always visible on `head_data`.

Software paces itself with a sticky request flag. In receive use the flag asks the host to drain the FIFO once enough bytes have collected. In transmit use it asks for more bytes once the FIFO has run low enough. Each direction has its own threshold, and one input selects whether the compare is inclusive or exclusive. A flush command empties the FIFO, and `flush_busy` stays high while the clear is under way. Three sticky error flags record host misuse: reading an empty FIFO, writing a full one, or accessing it against the current direction.

Top module: `ddc_byte_fifo`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, and `full`, `req_flag`, `flush_busy` and all three error flags are 0.
- R2: With `dir_rx`=0 (transmit), `host_wr` stores `host_wdata` and `eng_pop` removes the oldest byte. Bytes leave in the order they were written.
- R3: With `dir_rx`=1 (receive), `eng_push` stores `eng_wdata` and `host_rd` removes the oldest byte. Bytes leave in the order they arrived.
- R4: `level`, `full` (level equal to DEPTH) and `empty` (level 0) take their new values at the clock edge that performs a push or a pop. An accepted push and an accepted pop in the same cycle leave `level` unchanged. A push while full and a pop while empty are not performed.
- R5: In receive direction, the request condition is `level` > `rx_thresh` when `incl_cmp`=0, and `level` >= `rx_thresh` when `incl_cmp`=1.
- R6: In transmit direction, the request condition is `level` < `tx_thresh` when `incl_cmp`=0, and `level` <= `tx_thresh` when `incl_cmp`=1.
- R7: `req_flag` is set at any clock edge where the request condition holds. It is sticky. A clock edge with `req_clr`=1 clears it only when the condition is false in that cycle.
- R8: A `flush_req` pulse raises `flush_busy` for exactly one cycle. At the end of that cycle, `level` becomes 0 and `empty` becomes 1, and `flush_busy` falls by itself. Pushes and pops presented while `flush_busy` is 1 are discarded.
- R9: In receive direction, `host_rd` while `empty` is 1 sets `err_ufl`, and `level` stays 0.
- R10: In transmit direction, `host_wr` while `full` is 1 sets `err_ofl`. The byte is not stored.
- R11: `host_wr` in receive direction, or `host_rd` in transmit direction, sets `err_ill` and leaves the FIFO contents and `level` unchanged.
- R12: The error flags are sticky. Each is cleared at a clock edge with its bit of `err_clr` set: bit 0 clears `err_ufl`, bit 1 clears `err_ofl`, bit 2 clears `err_ill`. A clear does not affect the other two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 = receive (engine fills, host drains), 0 = transmit |
| incl_cmp | input | 1 | 1 = inclusive threshold compare |
| tx_thresh | input | LW | Transmit threshold (how empty) |
| rx_thresh | input | LW | Receive threshold (how full) |
| flush_req | input | 1 | Flush command pulse |
| flush_busy | output | 1 | High while a flush is in progress |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | DW | Host write byte |
| host_rd | input | 1 | Host byte read strobe |
| eng_push | input | 1 | Engine receive-byte strobe |
| eng_wdata | input | DW | Engine receive byte |
| eng_pop | input | 1 | Engine transmit-byte take strobe |
| head_data | output | DW | Oldest stored byte |
| level | output | LW | Number of stored bytes |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level is 0 |
| req_flag | output | 1 | Sticky threshold request |
| req_clr | input | 1 | Write-one clear for the request flag |
| err_clr | input | 3 | Write-one clears for the error flags |
| err_ufl | output | 1 | Receive underflow flag |
| err_ofl | output | 1 | Transmit overflow flag |
| err_ill | output | 1 | Illegal-access flag |

## Verification
The threshold compare is swept over every fill level from 0 to DEPTH, every threshold from 0 to DEPTH, both compare modes and both directions. This sweep finds off-by-one errors at the exact boundary of each mode, and also catches a swapped direction or a swapped mode. Ordered fill-and-drain runs in both directions use distinct byte values, so a pointer or wrap error shows up as a wrong head byte. A push and a pop in the same cycle, overflow writes followed by a full drain, wrong-direction accesses, and a flush with traffic on the busy cycle each show whether a rejected access altered the stored data. Per-bit error clears show that each flag is independent of the others.

// File: rtl/ddc_fifo_pkg.sv
package ddc_fifo_pkg;
  localparam int ERR_N   = 3;
  localparam int ERR_UFL = 0;
  localparam int ERR_OFL = 1;
  localparam int ERR_ILL = 2;
  typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/ddc_fifo_store.sv
module ddc_fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] head
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (push_en) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_en)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
        if (push_en && !clr && (wr_ptr_q == PW'(g))) mem[g] <= push_data;
      end
    end
  endgenerate

  assign head = mem[rd_ptr_q];
endmodule

// File: rtl/ddc_fifo_level.sv
module ddc_fifo_level #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_en,
  input  logic          pop_en,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [LW-1:0] LDEPTH = LW'(DEPTH);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          full_q, full_d, empty_q, empty_d;

  always_comb begin
    lvl_d = lvl_q;
    if (clr) begin
      lvl_d = '0;
    end else begin
      unique case ({push_en, pop_en})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
    full_d  = (lvl_d == LDEPTH);
    empty_d = (lvl_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      lvl_q   <= lvl_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign level = lvl_q;
  assign full  = full_q;
  assign empty = empty_q;
endmodule

// File: rtl/ddc_fifo_flags.sv
module ddc_fifo_flags
  import ddc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rx,
  input  logic          incl_cmp,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic [LW-1:0] level,
  input  logic          req_clr,
  input  err_vec_t      err_set,
  input  err_vec_t      err_clr,
  output logic          req_flag,
  output err_vec_t      err_flags
);
  logic     rx_hit, tx_hit, cond;
  logic     req_q, req_d;
  err_vec_t err_q, err_d;

  always_comb begin
    rx_hit = incl_cmp ? (level >= rx_thresh) : (level > rx_thresh);
    tx_hit = incl_cmp ? (level <= tx_thresh) : (level < tx_thresh);
    cond   = dir_rx ? rx_hit : tx_hit;
    req_d  = (req_q & ~req_clr) | cond;
    err_d  = (err_q & ~err_clr) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      err_q <= '0;
    end else begin
      req_q <= req_d;
      err_q <= err_d;
    end
  end

  assign req_flag  = req_q;
  assign err_flags = err_q;
endmodule

// File: rtl/ddc_byte_fifo.sv
module ddc_byte_fifo
  import ddc_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rx,
  input  logic          incl_cmp,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic          flush_req,
  output logic          flush_busy,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_wdata,
  input  logic          eng_pop,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          req_flag,
  input  logic          req_clr,
  input  logic [2:0]    err_clr,
  output logic          err_ufl,
  output logic          err_ofl,
  output logic          err_ill
);
  logic          flush_q, flush_d;
  logic          push_req, pop_req, push_en, pop_en;
  logic [DW-1:0] push_data;
  err_vec_t      err_set, err_flags;

  always_comb begin
    flush_d   = flush_q ? 1'b0 : flush_req;
    push_req  = dir_rx ? eng_push  : host_wr;
    push_data = dir_rx ? eng_wdata : host_wdata;
    pop_req   = dir_rx ? host_rd   : eng_pop;
    push_en   = push_req & ~full  & ~flush_q;
    pop_en    = pop_req  & ~empty & ~flush_q;
    err_set          = '0;
    err_set[ERR_UFL] = dir_rx  & host_rd & empty & ~flush_q;
    err_set[ERR_OFL] = ~dir_rx & host_wr & full  & ~flush_q;
    err_set[ERR_ILL] = (dir_rx & host_wr) | (~dir_rx & host_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  ddc_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush_q), .push_en(push_en),
    .push_data(push_data), .pop_en(pop_en), .head(head_data)
  );

  ddc_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(flush_q), .push_en(push_en),
    .pop_en(pop_en), .level(level), .full(full), .empty(empty)
  );

  ddc_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .incl_cmp(incl_cmp),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .level(level),
    .req_clr(req_clr), .err_set(err_set), .err_clr(err_vec_t'(err_clr)),
    .req_flag(req_flag), .err_flags(err_flags)
  );

  assign flush_busy = flush_q;
  assign err_ufl    = err_flags[ERR_UFL];
  assign err_ofl    = err_flags[ERR_OFL];
  assign err_ill    = err_flags[ERR_ILL];
endmodule

// File: rtl/ddc_byte_fifo_chk.sv
module ddc_byte_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_rx,
  input logic          incl_cmp,
  input logic [LW-1:0] tx_thresh,
  input logic [LW-1:0] rx_thresh,
  input logic          flush_req,
  input logic          flush_busy,
  input logic          host_wr,
  input logic          host_rd,
  input logic          eng_pop,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          req_flag,
  input logic          err_ufl,
  input logic          err_ofl,
  input logic          err_ill
);
  logic exp_cond;
  assign exp_cond = dir_rx ? (incl_cmp ? (level >= rx_thresh) : (level > rx_thresh))
                           : (incl_cmp ? (level <= tx_thresh) : (level < tx_thresh));

  // R4
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LW'(DEPTH)) && !(full && empty));

  // R4
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && host_wr && eng_pop && !full && !empty && !flush_busy) |=> $stable(level));

  // R7
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_cond |=> req_flag);

  // R8
  flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_busy) |=> flush_busy);

  // R8
  flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (!flush_busy && empty && level == '0));

  // R9
  ufl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && host_rd && empty && !flush_busy) |=> (err_ufl && empty));

  // R10
  ofl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && host_wr && full && !eng_pop && !flush_busy) |=> (err_ofl && full));

  // R11
  ill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_rx && host_wr) || (!dir_rx && host_rd)) |=> err_ill);
endmodule

bind ddc_byte_fifo ddc_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .incl_cmp(incl_cmp),
  .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .flush_req(flush_req),
  .flush_busy(flush_busy), .host_wr(host_wr), .host_rd(host_rd),
  .eng_pop(eng_pop), .level(level), .full(full), .empty(empty),
  .req_flag(req_flag), .err_ufl(err_ufl), .err_ofl(err_ofl), .err_ill(err_ill)
);

// File: tb/test_ddc_byte_fifo.sv
`timescale 1ns/1ps
module test_ddc_byte_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic dir_rx, incl_cmp, flush_req, host_wr, host_rd, eng_push, eng_pop, req_clr;
  logic [LW-1:0] tx_thresh, rx_thresh;
  logic [DW-1:0] host_wdata, eng_wdata;
  logic [2:0]    err_clr;
  logic          flush_busy, full, empty, req_flag, err_ufl, err_ofl, err_ill;
  logic [DW-1:0] head_data;
  logic [LW-1:0] level;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ddc_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) i_ddc_byte_fifo (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .incl_cmp(incl_cmp),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .flush_req(flush_req),
    .flush_busy(flush_busy), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .eng_push(eng_push), .eng_wdata(eng_wdata),
    .eng_pop(eng_pop), .head_data(head_data), .level(level), .full(full),
    .empty(empty), .req_flag(req_flag), .req_clr(req_clr), .err_clr(err_clr),
    .err_ufl(err_ufl), .err_ofl(err_ofl), .err_ill(err_ill)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic host_write(input logic [DW-1:0] b);
    host_wr = 1'b1; host_wdata = b; cyc(); host_wr = 1'b0;
  endtask

  task automatic engine_push(input logic [DW-1:0] b);
    eng_push = 1'b1; eng_wdata = b; cyc(); eng_push = 1'b0;
  endtask

  task automatic do_flush();
    flush_req = 1'b1; cyc(); flush_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir_rx = 1'b0; incl_cmp = 1'b0; flush_req = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; eng_push = 1'b0; eng_pop = 1'b0;
    req_clr = 1'b0; tx_thresh = '0; rx_thresh = LW'(DEPTH); err_clr = '0;
    host_wdata = '0; eng_wdata = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    // R1 reset state (tx_thresh 0 exclusive keeps the request condition false)
    chk(level == 0, "R1 level", int'(level), 0);
    chk(empty && !full, "R1 empty/full", {30'd0, full, empty}, 1);
    chk(!req_flag && !flush_busy, "R1 req/flush", {30'd0, req_flag, flush_busy}, 0);
    chk({err_ufl, err_ofl, err_ill} == 3'b000, "R1 errors",
        int'({err_ufl, err_ofl, err_ill}), 0);

    // R2 transmit fill in order, R4 level tracking, R10 overflow
    for (int i = 0; i < DEPTH; i++) begin
      host_write(pat(i));
      chk(level == LW'(i + 1), "R4 level on push", int'(level), i + 1);
    end
    chk(full && !empty, "R4 full at DEPTH", int'(full), 1);
    host_write(8'hEE);
    chk(err_ofl == 1'b1, "R10 overflow flag", int'(err_ofl), 1);
    chk(level == LW'(DEPTH), "R10 level held", int'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk(head_data == pat(i), "R2 transmit order", int'(head_data), int'(pat(i)));
      eng_pop = 1'b1; cyc(); eng_pop = 1'b0;
      chk(level == LW'(DEPTH - 1 - i), "R4 level on pop", int'(level), DEPTH - 1 - i);
    end
    chk(empty && !full, "R10 overflow byte not stored", int'(empty), 1);
    eng_pop = 1'b1; cyc(); eng_pop = 1'b0;
    chk(level == 0 && empty, "R4 pop when empty ignored", int'(level), 0);

    // R4 simultaneous push and pop
    host_write(8'h11); host_write(8'h22);
    host_wr = 1'b1; host_wdata = 8'h33; eng_pop = 1'b1; cyc();
    host_wr = 1'b0; eng_pop = 1'b0;
    chk(level == 2, "R4 push+pop level", int'(level), 2);
    chk(head_data == 8'h22, "R4 push+pop head", int'(head_data), 8'h22);

    // R11 host read in transmit direction
    host_rd = 1'b1; cyc(); host_rd = 1'b0;
    chk(err_ill == 1'b1, "R11 read in tx", int'(err_ill), 1);
    chk(level == 2 && head_data == 8'h22, "R11 tx contents kept", int'(level), 2);

    // R12 per-bit clears
    err_clr = 3'b010; cyc(); err_clr = 3'b000;
    chk(!err_ofl && err_ill, "R12 clear ofl only", int'({err_ofl, err_ill}), 1);
    err_clr = 3'b100; cyc(); err_clr = 3'b000;
    chk(!err_ill, "R12 clear ill", int'(err_ill), 0);

    // R8 flush, with a write presented on the busy cycle
    do_flush();
    chk(flush_busy == 1'b1, "R8 busy after request", int'(flush_busy), 1);
    host_write(8'h44);
    chk(!flush_busy && empty && level == 0, "R8 flush result", int'(level), 0);
    cyc();
    chk(level == 0 && !flush_busy, "R8 busy self clears", int'(flush_busy), 0);

    // R3 receive direction, R9 underflow, R11 write in rx
    dir_rx = 1'b1;
    for (int i = 0; i < 5; i++) engine_push(pat(i + 20));
    chk(level == 5, "R3 rx level", int'(level), 5);
    host_write(8'h55);
    chk(err_ill && level == 5, "R11 write in rx", int'(level), 5);
    for (int i = 0; i < 5; i++) begin
      chk(head_data == pat(i + 20), "R3 receive order", int'(head_data), int'(pat(i + 20)));
      host_rd = 1'b1; cyc(); host_rd = 1'b0;
    end
    chk(!err_ufl && empty, "R9 no underflow yet", int'(err_ufl), 0);
    host_rd = 1'b1; cyc(); host_rd = 1'b0;
    chk(err_ufl && level == 0, "R9 underflow flag", int'(err_ufl), 1);
    err_clr = 3'b001; cyc(); err_clr = 3'b000;
    chk(!err_ufl && err_ill, "R12 clear ufl only", int'({err_ufl, err_ill}), 1);
    err_clr = 3'b111; cyc(); err_clr = 3'b000;

    // R7 sticky request in transmit direction
    dir_rx = 1'b0; incl_cmp = 1'b0; tx_thresh = LW'(1); rx_thresh = '0;
    do_flush(); cyc();
    chk(req_flag == 1'b1, "R7 set when empty", int'(req_flag), 1);
    host_write(8'h66);
    cyc();
    chk(req_flag == 1'b1, "R7 sticky", int'(req_flag), 1);
    req_clr = 1'b1; cyc(); req_clr = 1'b0;
    chk(req_flag == 1'b0, "R7 cleared", int'(req_flag), 0);

    // R5 / R6 sweep: every level, threshold, compare mode and direction
    for (int d = 0; d < 2; d++) begin
      dir_rx = d[0];
      do_flush(); cyc();
      for (int lv = 0; lv <= DEPTH; lv++) begin
        for (int inc = 0; inc < 2; inc++) begin
          for (int th = 0; th <= DEPTH; th++) begin
            bit e;
            incl_cmp = inc[0];
            tx_thresh = LW'(th); rx_thresh = LW'(th);
            req_clr = 1'b1; cyc(); req_clr = 1'b0;
            if (d == 1) e = inc ? (lv >= th) : (lv > th);
            else        e = inc ? (lv <= th) : (lv < th);
            if (d == 1) chk(req_flag == e, "R5 rx threshold", int'(req_flag), int'(e));
            else        chk(req_flag == e, "R6 tx threshold", int'(req_flag), int'(e));
          end
        end
        if (lv < DEPTH) begin
          if (d == 1) engine_push(pat(lv));
          else        host_write(pat(lv));
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule